// File: doc/BRIEF.md
# Stream Handshake Protocol Monitor

A passive observer for a single-clock ready/valid link that carries a data word together with packet-start and packet-end markers. It watches the link every cycle and never drives it. When either endpoint breaks the handshake contract, the monitor raises a sticky flag and records a code for the earliest violation.

Each endpoint's guarantees are given as parameters. The upstream may promise to keep the beat steady while it waits, and it may insist that the receiver looks at the beat only when valid is high. The downstream may depend on that steady beat, and it may be a receiver that is always ready and reads the data every cycle without looking at valid. A pairing that cannot work is reported on a constant configuration-error output. Framing consistency is optional. When it is on, the start marker is compared with a value that the monitor rebuilds from the end marker. With every guarantee off, the only active check is the one that catches valid depending on ready.

Top module: `hs_link_monitor`

## Requirements
- R1: `cfg_err` is 1 exactly when (DN_NEEDS_HOLD and not UP_HOLDS) or (DN_BLIND and UP_FORBIDS_BLIND). It holds that value for all cycles, including reset.
- R2: A dependency violation is recorded in flag bit 0 (code 1). It is detected in a cycle where valid and ready both change relative to the previous cycle, in opposite directions, and the previous cycle was not a transfer. Both rising together is legal.
- R3: With UP_HOLDS set, valid falling after a cycle with valid=1 and ready=0 is a drop violation, recorded in flag bit 1 (code 2).
- R4: With UP_HOLDS set, any change of data, first or last while valid stays high after a cycle with valid=1 and ready=0 is a hold violation, recorded in flag bit 2 (code 3).
- R5: With CHECK_FIRST set, the expected start marker is 1 after reset and after a transfer with last=1, and 0 after any other transfer. A transfer whose first differs from it is a framing violation, recorded in flag bit 3 (code 4).
- R6: With DN_BLIND set, the receiver must keep ready high every cycle. Any cycle with ready=0 is recorded in flag bit 4 (code 5).
- R7: A flag is set on the clock edge that ends the offending cycle. It stays set until reset, and reset clears all flags.
- R8: `viol_code` is 0 until the first violation. It then keeps the code of that violation until reset. If several violations occur in the same cycle, the lowest code wins.
- R9: With all guarantee parameters and CHECK_FIRST at their default 0, only the R2 check can raise a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_valid | input | 1 | Observed valid |
| link_ready | input | 1 | Observed ready |
| link_data | input | DATA_W | Observed data word |
| link_first | input | 1 | Observed packet-start marker |
| link_last | input | 1 | Observed packet-end marker |
| cfg_err | output | 1 | Incompatible endpoint guarantees |
| viol_flags | output | 5 | Sticky violation flags, bit k carries code k+1 |
| viol_code | output | 3 | Code of the first violation, 0 when none |

## Verification
Each rule compares the current link values with registers taken on the previous edge. A violation in the cycle ending at edge E therefore shows in `viol_flags` and `viol_code` just after E. The bench drives one beat per cycle on the falling edge and samples 1 ns after the following rising edge, which is the first moment the result exists. After reset is released, the internal reset needs two edges to release, and the bench adds idle cycles before any stimulus. `cfg_err` is a constant, so it is read once for each of the sixteen guarantee combinations, with the expected value worked out in the bench.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int NUM_VIOL = 5;
  localparam int CODE_W   = $clog2(NUM_VIOL + 1);
  // flag bit positions; code reported is position + 1, lower wins
  localparam int IDX_DEP   = 0;
  localparam int IDX_DROP  = 1;
  localparam int IDX_HOLD  = 2;
  localparam int IDX_FRAME = 3;
  localparam int IDX_READY = 4;
endpackage

// File: rtl/hsm_rst_sync.sv
module hsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/hsm_history.sv
module hsm_history #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              valid,
  input  logic              ready,
  input  logic [DATA_W-1:0] data,
  input  logic              first,
  input  logic              last,
  output logic              prev_valid,
  output logic              prev_ready,
  output logic [DATA_W+1:0] prev_beat,
  output logic              exp_first
);
  localparam int BEAT_W = DATA_W + 2;

  logic [BEAT_W-1:0] beat_d;
  logic              xfer;
  logic              exp_d;
  logic              exp_en;

  always_comb begin
    beat_d = {data, first, last};
    xfer   = valid & ready;
    exp_en = xfer;
    exp_d  = last;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_valid <= 1'b0;
      prev_ready <= 1'b0;
      prev_beat  <= '0;
      exp_first  <= 1'b1;
    end else begin
      prev_valid <= valid;
      prev_ready <= ready;
      prev_beat  <= beat_d;
      if (exp_en) exp_first <= exp_d;
    end
  end
endmodule

// File: rtl/hsm_rules.sv
module hsm_rules
  import hsm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit UP_HOLDS    = 1'b0,
  parameter bit DN_BLIND    = 1'b0,
  parameter bit CHECK_FIRST = 1'b0
) (
  input  logic                valid,
  input  logic                ready,
  input  logic [DATA_W-1:0]   data,
  input  logic                first,
  input  logic                last,
  input  logic                prev_valid,
  input  logic                prev_ready,
  input  logic [DATA_W+1:0]   prev_beat,
  input  logic                exp_first,
  output logic [NUM_VIOL-1:0] hit
);
  logic stalled;
  logic prev_xfer;
  logic beat_moved;

  always_comb begin
    stalled    = prev_valid & ~prev_ready;
    prev_xfer  = prev_valid & prev_ready;
    beat_moved = ({data, first, last} != prev_beat);

    hit = '0;
    hit[IDX_DEP]   = (valid ^ prev_valid) & (ready ^ prev_ready) &
                     (valid ^ ready) & ~prev_xfer;
    hit[IDX_DROP]  = UP_HOLDS & stalled & ~valid;
    hit[IDX_HOLD]  = UP_HOLDS & stalled & valid & beat_moved;
    hit[IDX_FRAME] = CHECK_FIRST & valid & ready & (first != exp_first);
    hit[IDX_READY] = DN_BLIND & ~ready;
  end
endmodule

// File: rtl/hsm_flags.sv
module hsm_flags #(
  parameter int NUM_VIOL = 5,
  parameter int CODE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_q_n,
  input  logic [NUM_VIOL-1:0] hit,
  output logic [NUM_VIOL-1:0] flags_q,
  output logic [CODE_W-1:0]   code_q
);
  logic [NUM_VIOL-1:0] flags_d;
  logic [CODE_W-1:0]   lead_code;
  logic                flags_en;
  logic                code_en;

  always_comb begin
    lead_code = '0;
    for (int i = NUM_VIOL - 1; i >= 0; i--) begin
      if (hit[i]) lead_code = CODE_W'(i + 1);
    end
    flags_d  = flags_q | hit;
    flags_en = |hit;
    code_en  = (code_q == '0) & (|hit);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flags_q <= '0;
      code_q  <= '0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      if (code_en)  code_q  <= lead_code;
    end
  end
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
  import hsm_pkg::*;
#(
  parameter int DATA_W           = 8,
  parameter bit UP_HOLDS         = 1'b0,
  parameter bit DN_NEEDS_HOLD    = 1'b0,
  parameter bit DN_BLIND         = 1'b0,
  parameter bit UP_FORBIDS_BLIND = 1'b0,
  parameter bit CHECK_FIRST      = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_valid,
  input  logic                link_ready,
  input  logic [DATA_W-1:0]   link_data,
  input  logic                link_first,
  input  logic                link_last,
  output logic                cfg_err,
  output logic [NUM_VIOL-1:0] viol_flags,
  output logic [CODE_W-1:0]   viol_code
);
  localparam bit BAD_CFG = (DN_NEEDS_HOLD && !UP_HOLDS) ||
                           (DN_BLIND && UP_FORBIDS_BLIND);

  logic              rst_q_n;
  logic              prev_valid;
  logic              prev_ready;
  logic [DATA_W+1:0] prev_beat;
  logic              exp_first;
  logic [NUM_VIOL-1:0] hit;

  assign cfg_err = BAD_CFG;

  hsm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  hsm_history #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_q_n(rst_q_n),
    .valid(link_valid), .ready(link_ready), .data(link_data),
    .first(link_first), .last(link_last),
    .prev_valid(prev_valid), .prev_ready(prev_ready),
    .prev_beat(prev_beat), .exp_first(exp_first)
  );

  hsm_rules #(
    .DATA_W(DATA_W), .UP_HOLDS(UP_HOLDS),
    .DN_BLIND(DN_BLIND), .CHECK_FIRST(CHECK_FIRST)
  ) u_rules (
    .valid(link_valid), .ready(link_ready), .data(link_data),
    .first(link_first), .last(link_last),
    .prev_valid(prev_valid), .prev_ready(prev_ready),
    .prev_beat(prev_beat), .exp_first(exp_first), .hit(hit)
  );

  hsm_flags #(.NUM_VIOL(NUM_VIOL), .CODE_W(CODE_W)) u_flags (
    .clk(clk), .rst_q_n(rst_q_n), .hit(hit),
    .flags_q(viol_flags), .code_q(viol_code)
  );
endmodule

// File: rtl/hs_link_monitor_chk.sv
module hs_link_monitor_chk
  import hsm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit UP_HOLDS    = 1'b0,
  parameter bit DN_BLIND    = 1'b0
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                link_valid,
  input logic                link_ready,
  input logic [DATA_W-1:0]   link_data,
  input logic                link_first,
  input logic                link_last,
  input logic [NUM_VIOL-1:0] viol_flags,
  input logic [CODE_W-1:0]   viol_code
);
  logic seen;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) seen <= 1'b0;
    else          seen <= 1'b1;
  end

  // R2: opposite toggles without a preceding transfer are recorded
  p_dep_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen && (link_valid != $past(link_valid)) &&
     (link_ready != $past(link_ready)) && (link_valid != link_ready) &&
     !($past(link_valid) && $past(link_ready))) |=> viol_flags[IDX_DEP]);

  generate
    if (UP_HOLDS) begin : g_hold
      // R3: valid withdrawn during a stall
      p_drop_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
        (seen && $past(link_valid && !link_ready) && !link_valid)
        |=> viol_flags[IDX_DROP]);
      // R4: data moved during a stall
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
        (seen && $past(link_valid && !link_ready) && link_valid &&
         (link_data != $past(link_data))) |=> viol_flags[IDX_HOLD]);
    end
    if (DN_BLIND) begin : g_blind
      // R6: always-ready receiver dropped ready
      p_ready_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
        !link_ready |=> viol_flags[IDX_READY]);
    end
    for (genvar i = 0; i < NUM_VIOL; i++) begin : g_sticky
      // R7: flags never clear outside reset
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
        viol_flags[i] |=> viol_flags[i]);
    end
  endgenerate

  // R8: first code is frozen once recorded
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (viol_code != '0) |=> $stable(viol_code));

  // R8: a code is present exactly when some flag is set
  p_code_flags_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (viol_code == '0) == (viol_flags == '0));
endmodule

bind hs_link_monitor hs_link_monitor_chk #(
  .DATA_W(DATA_W), .UP_HOLDS(UP_HOLDS), .DN_BLIND(DN_BLIND)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n),
  .link_valid(link_valid), .link_ready(link_ready), .link_data(link_data),
  .link_first(link_first), .link_last(link_last),
  .viol_flags(viol_flags), .viol_code(viol_code)
);

// File: tb/hs_link_monitor_bench.sv
module hs_link_monitor_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, r = 1'b1, f = 1'b0, l = 1'b0;
  logic [DW-1:0] d = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  logic       cfg_m, cfg_d, cfg_b;
  logic [4:0] fl_m, fl_d, fl_b;
  logic [2:0] cd_m, cd_d, cd_b;
  logic [15:0] cfg_sweep;

  // main: holding upstream, hold-needing downstream, framing on
  hs_link_monitor #(.DATA_W(DW), .UP_HOLDS(1'b1), .DN_NEEDS_HOLD(1'b1),
    .DN_BLIND(1'b0), .UP_FORBIDS_BLIND(1'b1), .CHECK_FIRST(1'b1))
  u_hs_link_monitor (
    .clk(clk), .rst_n(rst_n), .link_valid(v), .link_ready(r), .link_data(d),
    .link_first(f), .link_last(l), .cfg_err(cfg_m), .viol_flags(fl_m),
    .viol_code(cd_m));

  hs_link_monitor #(.DATA_W(DW)) u_dflt (
    .clk(clk), .rst_n(rst_n), .link_valid(v), .link_ready(r), .link_data(d),
    .link_first(f), .link_last(l), .cfg_err(cfg_d), .viol_flags(fl_d),
    .viol_code(cd_d));

  hs_link_monitor #(.DATA_W(DW), .DN_BLIND(1'b1)) u_blind (
    .clk(clk), .rst_n(rst_n), .link_valid(v), .link_ready(r), .link_data(d),
    .link_first(f), .link_last(l), .cfg_err(cfg_b), .viol_flags(fl_b),
    .viol_code(cd_b));

  for (genvar g = 0; g < 16; g++) begin : g_cfg
    logic [4:0] unused_fl;
    logic [2:0] unused_cd;
    hs_link_monitor #(.DATA_W(DW),
      .UP_HOLDS(bit'(g & 1)), .DN_NEEDS_HOLD(bit'((g >> 1) & 1)),
      .DN_BLIND(bit'((g >> 2) & 1)), .UP_FORBIDS_BLIND(bit'((g >> 3) & 1)))
    u_cfg (
      .clk(clk), .rst_n(rst_n), .link_valid(v), .link_ready(r), .link_data(d),
      .link_first(f), .link_last(l), .cfg_err(cfg_sweep[g]),
      .viol_flags(unused_fl), .viol_code(unused_cd));
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one link cycle: drive after falling edge, sample just after rising edge
  task automatic beat(input logic vv, input logic rr, input logic [DW-1:0] dd,
                      input logic ff, input logic ll);
    @(negedge clk);
    v = vv; r = rr; d = dd; f = ff; l = ll;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 1'b0; r = 1'b1; d = '0; f = 1'b0; l = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R7 reset clears main flags", fl_m, 0);
    chk("R8 reset clears main code", cd_m, 0);
  endtask

  initial begin
    #1;
    // R1: every guarantee combination
    for (int g = 0; g < 16; g++) begin
      int uh, nh, bl, fb;
      uh = g & 1; nh = (g >> 1) & 1; bl = (g >> 2) & 1; fb = (g >> 3) & 1;
      chk($sformatf("R1 cfg_err combo %0d", g), cfg_sweep[g],
          ((nh == 1 && uh == 0) || (bl == 1 && fb == 1)) ? 1 : 0);
    end
    chk("R1 main cfg_err", cfg_m, 0);

    // S1: legal traffic with stalls and two packets
    do_reset();
    beat(0, 0, 8'h00, 0, 0);
    beat(1, 0, 8'hA1, 1, 0);
    beat(1, 1, 8'hA1, 1, 0);
    beat(1, 0, 8'hB2, 0, 0);
    beat(1, 1, 8'hB2, 0, 0);
    beat(1, 1, 8'hC3, 0, 1);
    beat(0, 1, 8'h00, 0, 0);
    beat(1, 1, 8'hD4, 1, 1);
    beat(0, 0, 8'h00, 0, 0);
    chk("R5 legal framing no flags main", fl_m, 0);
    chk("R2 legal traffic no flags default", fl_d, 0);

    // S2: dependency then dependency+drop
    do_reset();
    beat(1, 0, 8'h11, 1, 0);
    chk("R2 dep flag main", fl_m, 1);
    chk("R2 dep code main", cd_m, 1);
    chk("R2 dep flag default", fl_d, 1);
    beat(0, 1, 8'h00, 0, 0);
    chk("R3 drop adds flag main", fl_m, 3);
    chk("R8 code kept main", cd_m, 1);
    chk("R9 default ignores drop", fl_d, 1);

    // S3: hold violation, later dep+drop, code stays 3
    do_reset();
    beat(0, 0, 8'h00, 0, 0);
    beat(1, 0, 8'h05, 1, 0);
    beat(1, 0, 8'h06, 1, 0);
    chk("R4 hold flag main", fl_m, 4);
    chk("R4 hold code main", cd_m, 3);
    chk("R9 default ignores hold", fl_d, 0);
    beat(1, 1, 8'h06, 1, 0);
    beat(0, 0, 8'h00, 0, 0);
    beat(1, 0, 8'h07, 1, 1);
    beat(0, 1, 8'h00, 0, 0);
    chk("R7 flags accumulate main", fl_m, 7);
    chk("R8 first code kept main", cd_m, 3);
    chk("R2 default dep flag", fl_d, 1);
    chk("R2 default dep code", cd_d, 1);

    // S4: framing
    do_reset();
    beat(1, 1, 8'h21, 0, 0);
    chk("R5 missing first flagged", fl_m, 8);
    chk("R5 frame code", cd_m, 4);
    chk("R9 default ignores framing", fl_d, 0);
    beat(1, 1, 8'h22, 1, 1);
    beat(1, 1, 8'h23, 1, 0);
    beat(1, 1, 8'h24, 0, 1);
    beat(0, 1, 8'h00, 0, 0);
    chk("R5 only frame flag", fl_m, 8);

    // S5: simultaneous dep and drop, lowest code wins
    do_reset();
    beat(0, 0, 8'h00, 0, 0);
    beat(1, 0, 8'h31, 1, 0);
    chk("R3 no flag before drop", fl_m, 0);
    beat(0, 1, 8'h00, 0, 0);
    chk("R8 both flags same cycle", fl_m, 3);
    chk("R8 lowest code wins", cd_m, 1);

    // S6: always-ready receiver
    do_reset();
    chk("R6 blind reset flags", fl_b, 0);
    beat(1, 1, 8'h41, 1, 0);
    beat(1, 1, 8'h42, 0, 1);
    beat(0, 1, 8'h00, 0, 0);
    chk("R6 blind legal no flags", fl_b, 0);
    beat(0, 0, 8'h00, 0, 0);
    chk("R6 ready drop flag", fl_b, 16);
    chk("R6 ready drop code", cd_b, 5);
    beat(0, 1, 8'h00, 0, 0);
    chk("R7 blind flag sticky", fl_b, 16);
    chk("R1 blind cfg ok", cfg_b, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule